// File: doc/BRIEF.md
# Two-Channel Bridge PWM Generator with Sync Master/Slave Timebase

This block produces pulse-width-modulated drive for two bridge-tied loads. Each channel has a positive and a negative output; a signed duty command widens one and narrows the other around the 50% point. The result is a differential drive, and a command of zero gives equal pulses on both halves of the bridge.

The switching period comes from one of two sources. In master mode a counter of the system clock sets the period, and the block drives a sync output that runs at twice the switching rate, so that other generators can follow it. When the oscillator-setting strap is reported as unconnected, the block is a slave. The sync pin then becomes an input, and every second synchronized rising edge on it starts a new switching period.

A controller can request mute, which forces both outputs of every channel to exactly 50% duty. It can also request high impedance, which removes the enables of all outputs. Duty and mute requests take effect only at a period boundary, so a pulse is never cut short partway.

Top module: `sync_pwm_gen`

## Requirements
- R1: In master mode (`osc_open`=0) the switching period is PERIOD system clocks. Each period, `pwm_p[c]` is high for HALF+d cycles and `pwm_n[c]` for HALF-d cycles, with HALF=PERIOD/2 and d the latched signed duty of channel c. Each output rises once per period when 0<HALF±d<PERIOD.
- R2: In master mode `sync_oe`=1 and `sync_o` rises twice in every switching period, which is twice the switching rate.
- R3: With `osc_open`=1, `sync_oe`=0 and `sync_o` is held low.
- R4: In slave mode the sync input passes a two-stage synchronizer, and every second synchronized rising edge starts a period. The switching period is therefore two sync periods. Within it, `pwm_p[c]` is high for HALF+d cycles and `pwm_n[c]` for HALF-d cycles, limited to the period length.
- R5: The duty is clamped to the range [-HALF, +HALF]. At +HALF or above, `pwm_p` is high for the whole period and `pwm_n` stays low. At -HALF the reverse holds.
- R6: While a latched mute is in force, both outputs of every channel are high for exactly HALF cycles of each period, whatever the duty.
- R7: Duty and mute commands are sampled only on the cycle that starts a new period. A change in the middle of a period leaves the current period unchanged and applies to the next one.
- R8: `hiz`=1 clears all bits of `oe_p` and `oe_n` from the next clock edge. Once `hiz` returns to 0 they are all set again one cycle later.
- R9: While `rst_n`=0, all output enables are low and the latched duty is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_open | input | 1 | Strap: 1 = oscillator input unconnected (slave mode) |
| sync_i | input | 1 | Sync clock from a master (slave mode) |
| mute | input | 1 | Mute request, sampled at period start |
| hiz | input | 1 | High-impedance request |
| duty | input | CH*DUTY_W | Signed duty command per channel, channel c in bits [c*DUTY_W +: DUTY_W] |
| sync_o | output | 1 | Sync clock out, twice the switching rate (master) |
| sync_oe | output | 1 | Drive enable for the sync pin |
| pwm_p | output | CH | Positive bridge-half PWM per channel |
| pwm_n | output | CH | Negative bridge-half PWM per channel |
| oe_p | output | CH | Output enable for pwm_p |
| oe_n | output | CH | Output enable for pwm_n |

## Verification
A new duty or mute command can arrive in the same cycle range as the boundary of a period. The bench changes the duty right after a period has begun. It then counts the high cycles of that period and of the next one, and expects the old width first and the new width after it. Mute is also mixed into random duty commands, so mute and a non-zero duty land in the same period, and the judgement is that both halves read HALF. A high-impedance request is raised while the outputs are switching, and the enables must drop on the next edge.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;

  // Limit a signed duty request to the symmetric swing around mid-period.
  function automatic int clamp_duty(input int d, input int half);
    if (d > half) return half;
    if (d < -half) return -half;
    return d;
  endfunction

  // Number of high cycles of the positive half.
  function automatic int pos_thresh(input int d, input int half, input logic muted);
    return muted ? half : half + d;
  endfunction

  // Number of high cycles of the negative half.
  function automatic int neg_thresh(input int d, input int half, input logic muted);
    return muted ? half : half - d;
  endfunction

endpackage

// File: rtl/spg_sync_edge.sv
module spg_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic sync_i,
  output logic start_s
);
  logic s1, s2, s3, ph;
  logic rise;

  assign rise    = s2 & ~s3;
  assign start_s = slave & rise & ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      ph <= 1'b0;
    end else begin
      s1 <= sync_i;
      s2 <= s1;
      s3 <= s2;
      if (!slave)   ph <= 1'b0;
      else if (rise) ph <= ~ph;
    end
  end

  // R4: a period start happens on the second edge, after which the phase is back at the first
  p_phase_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> !ph);

endmodule

// File: rtl/spg_timebase.sv
module spg_timebase #(
  parameter int PERIOD = 32,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave,
  input  logic             start_s,
  output logic [CNT_W-1:0] ctr,
  output logic             pstart,
  output logic             sync_o
);
  localparam int QTR = PERIOD / 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic wrap_m;

  assign wrap_m = !slave && (int'(ctr) >= PERIOD - 1);
  assign pstart = slave ? start_s : wrap_m;
  assign sync_o = !slave && ((int'(ctr) % (2 * QTR)) < QTR);

  always_ff @(posedge clk) begin
    if (!rst_n)          ctr <= '0;
    else if (pstart)     ctr <= '0;
    else if (ctr != CMAX) ctr <= ctr + 1'b1;
  end

  // R1: every period start restarts the count
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pstart |=> ctr == '0);

  // R1: in master mode the last count of the period is a period start
  p_master_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && int'(ctr) == PERIOD - 1) |-> pstart);

endmodule

// File: rtl/spg_channel.sv
module spg_channel
  import sync_pwm_pkg::*;
#(
  parameter int PERIOD = 32,
  parameter int DUTY_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pstart,
  input  logic [CNT_W-1:0]  ctr,
  input  logic              mute,
  input  logic [DUTY_W-1:0] duty,
  output logic              pos,
  output logic              neg
);
  localparam int HALF = PERIOD / 2;
  localparam int DQ_W = CNT_W + 1;

  logic signed [DQ_W-1:0] dq;
  logic                   mq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq <= '0;
      mq <= 1'b0;
    end else if (pstart) begin
      dq <= DQ_W'(clamp_duty(int'($signed(duty)), HALF));
      mq <= mute;
    end
  end

  assign pos = int'(ctr) < pos_thresh(int'(dq), HALF, mq);
  assign neg = int'(ctr) < neg_thresh(int'(dq), HALF, mq);

  // R7: latched duty only moves on a period start
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pstart |=> $stable(dq));

  // R6: while muted both halves share the same pulse
  p_mute_sym_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mq |-> (pos == neg));

  // R5: latched duty stays inside the swing
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dq) >= -HALF) && (int'(dq) <= HALF));

endmodule

// File: rtl/sync_pwm_gen.sv
module sync_pwm_gen #(
  parameter int CH     = 2,
  parameter int PERIOD = 32,
  parameter int DUTY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_open,
  input  logic             sync_i,
  input  logic             mute,
  input  logic             hiz,
  input  logic [CH*DUTY_W-1:0] duty,
  output logic             sync_o,
  output logic             sync_oe,
  output logic [CH-1:0]    pwm_p,
  output logic [CH-1:0]    pwm_n,
  output logic [CH-1:0]    oe_p,
  output logic [CH-1:0]    oe_n
);
  localparam int CNT_W = $clog2(PERIOD) + 1;

  logic             start_s;
  logic             pstart;
  logic [CNT_W-1:0] ctr;
  logic             oe_q;

  spg_sync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .slave   (osc_open),
    .sync_i  (sync_i),
    .start_s (start_s)
  );

  spg_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .slave   (osc_open),
    .start_s (start_s),
    .ctr     (ctr),
    .pstart  (pstart),
    .sync_o  (sync_o)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    spg_channel #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pstart (pstart),
      .ctr    (ctr),
      .mute   (mute),
      .duty   (duty[c*DUTY_W +: DUTY_W]),
      .pos    (pwm_p[c]),
      .neg    (pwm_n[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= ~hiz;
  end

  assign oe_p    = {CH{oe_q}};
  assign oe_n    = {CH{oe_q}};
  assign sync_oe = ~osc_open;

  // R8: a high-impedance request drops every enable on the next edge
  p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |=> (oe_p == '0) && (oe_n == '0));

  // R3: a slave never drives a sync pulse
  p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_open |-> !sync_o);

endmodule

// File: tb/sync_pwm_gen_test.sv
module sync_pwm_gen_test;
  localparam int CLK_P  = 10;
  localparam int CH     = 2;
  localparam int PERIOD = 32;
  localparam int HALF   = PERIOD / 2;
  localparam int DUTY_W = 6;

  logic clk = 0, rst_n = 0, osc_open = 0, sync_i = 0, mute = 0, hiz = 0;
  logic [CH*DUTY_W-1:0] duty = '0;
  logic sync_o, sync_oe;
  logic [CH-1:0] pwm_p, pwm_n, oe_p, oe_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit sync_run = 0;
  int sync_half = 8;

  sync_pwm_gen #(.CH(CH), .PERIOD(PERIOD), .DUTY_W(DUTY_W)) uut (
    .clk(clk), .rst_n(rst_n), .osc_open(osc_open), .sync_i(sync_i),
    .mute(mute), .hiz(hiz), .duty(duty), .sync_o(sync_o), .sync_oe(sync_oe),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .oe_p(oe_p), .oe_n(oe_n));

  always #(CLK_P/2) clk = ~clk;

  // external sync source for slave tests
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (sync_run) begin
        k++;
        if (k >= sync_half) begin
          k = 0;
          sync_i = ~sync_i;
        end
      end else k = 0;
    end
  end

  function automatic int exp_clamp(int d);
    return (d > HALF) ? HALF : ((d < -HALF) ? -HALF : d);
  endfunction
  function automatic int exp_high(int d, bit m, bit is_pos, int plen);
    int h;
    h = m ? HALF : (is_pos ? HALF + exp_clamp(d) : HALF - exp_clamp(d));
    return (h > plen) ? plen : h;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_duty(int d0, int d1);
    duty = {DUTY_W'(d1), DUTY_W'(d0)};
  endtask

  // count high cycles and rising edges over n negedge samples
  task automatic window(int n, output int hp0, output int hn0, output int hp1,
                        output int hn1, output int rp0, output int rs);
    logic pp, ps;
    hp0 = 0; hn0 = 0; hp1 = 0; hn1 = 0; rp0 = 0; rs = 0;
    pp = pwm_p[0]; ps = sync_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hp0 += int'(pwm_p[0]); hn0 += int'(pwm_n[0]);
      hp1 += int'(pwm_p[1]); hn1 += int'(pwm_n[1]);
      if (pwm_p[0] && !pp) rp0++;
      if (sync_o && !ps) rs++;
      pp = pwm_p[0]; ps = sync_o;
    end
  endtask

  task automatic run_case(string req, int d0, int d1, bit m, int plen);
    int hp0, hn0, hp1, hn1, rp0, rs;
    set_duty(d0, d1); mute = m;
    repeat (3 * plen + 4) @(negedge clk);
    window(plen, hp0, hn0, hp1, hn1, rp0, rs);
    check({req, " pos0"}, hp0, exp_high(d0, m, 1, plen));
    check({req, " neg0"}, hn0, exp_high(d0, m, 0, plen));
    check({req, " pos1"}, hp1, exp_high(d1, m, 1, plen));
    check({req, " neg1"}, hn1, exp_high(d1, m, 0, plen));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hp0, hn0, hp1, hn1, rp0, rs;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 oe_p in reset", int'(oe_p), 0);
    check("R9 oe_n in reset", int'(oe_n), 0);
    check("R9 pos at zero duty", int'(pwm_p), 3);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R8 oe after reset", int'(oe_p & oe_n), 3);

    // R1 master basic and R2 sync rate
    run_case("R1 master", 5, -7, 0, PERIOD);
    window(4 * PERIOD, hp0, hn0, hp1, hn1, rp0, rs);
    check("R1 pos rises per 4 periods", rp0, 4);
    check("R2 sync rises per 4 periods", rs, 8);
    check("R2 sync_oe master", int'(sync_oe), 1);

    // R5 clamp
    run_case("R5 clamp high", 20, -31, 0, PERIOD);
    run_case("R5 exact swing", 16, -16, 0, PERIOD);

    // R6 mute
    run_case("R6 mute", 10, -12, 1, PERIOD);
    mute = 0;

    // R7 mid-period change
    set_duty(4, 4);
    repeat (3 * PERIOD) @(negedge clk);
    begin
      logic pp;
      pp = pwm_p[0];
      forever begin
        @(negedge clk);
        if (pwm_p[0] && !pp) break;
        pp = pwm_p[0];
      end
    end
    set_duty(-4, -4);
    window(PERIOD - 1, hp0, hn0, hp1, hn1, rp0, rs);
    check("R7 current period keeps old duty", hp0 + 1, HALF + 4);
    window(PERIOD, hp0, hn0, hp1, hn1, rp0, rs);
    check("R7 next period takes new duty", hp0, HALF - 4);

    // R8 hiz during switching
    @(negedge clk); hiz = 1;
    @(negedge clk);
    check("R8 oe_p cleared", int'(oe_p), 0);
    check("R8 oe_n cleared", int'(oe_n), 0);
    hiz = 0;
    @(negedge clk);
    check("R8 oe restored", int'(oe_p & oe_n), 3);

    // random master cases
    for (int it = 0; it < 16; it++) begin
      int a, b;
      bit m;
      a = int'($urandom_range(48)) - 24;
      b = int'($urandom_range(48)) - 24;
      m = ($urandom_range(3) == 0);
      run_case(m ? "R6 random mute" : "R1 random", a, b, m, PERIOD);
    end
    mute = 0;

    // slave mode
    osc_open = 1; sync_half = 8; sync_run = 1;
    repeat (2) @(negedge clk);
    check("R3 sync_oe slave", int'(sync_oe), 0);
    check("R3 sync_o slave", int'(sync_o), 0);
    run_case("R4 slave matched", 6, -3, 0, 4 * sync_half);
    window(4 * 4 * sync_half, hp0, hn0, hp1, hn1, rp0, rs);
    check("R4 slave pos rises", rp0, 4);
    check("R3 sync_o stays low", rs, 0);
    sync_half = 10;
    run_case("R4 slave longer", 6, -9, 0, 4 * sync_half);
    run_case("R4 slave clamp", 25, -25, 0, 4 * sync_half);
    sync_half = 6;
    run_case("R4 slave shorter", 2, -2, 0, 4 * sync_half);
    run_case("R6 slave mute", 9, 3, 1, 4 * sync_half);
    sync_run = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule